// File: doc/BRIEF.md
# Vertical Transfer Pattern Sequencer

This block produces the thirteen vertical transfer clocks that shift charge rows in an image sensor. It runs its own pixel counter across each line. The counter length comes from a programmable line-length value, and the line parity alternates from one line to the next. Each output follows a pulse pattern taken from one of two pattern groups. A group is described by a frame and by a toggle table. The frame has a start pixel, a repeat length, and one repeat count for odd lines and another for even lines. The toggle table holds a start polarity and six toggle offsets for every output.

A per-output select mask assigns each output to group A or group B. A merge flag overrides the mask and gives every output the union of both groups' toggle offsets, all placed inside group A's frame and started from group A's polarity. The current pixel count and line parity are driven out so that neighbouring timing logic can stay aligned to the same line.

Top module: `vts_vertical_seq`

## Requirements
- R1: `pix_cnt` counts up by one per clock from 0. In the clock after a cycle where `pix_cnt + 1 >= line_len`, it returns to 0. Line lengths up to 8192 are supported.
- R2: The first line after reset is odd (`line_odd` = 1). `line_odd` inverts at every return of `pix_cnt` to 0 and holds at all other times.
- R3: Synchronous active-high reset sets `pix_cnt` to 0 and `line_odd` to 1. Whenever `pix_cnt` is 0, each `xv[i]` equals the start polarity of the group that governs it.
- R4: A frame hit happens at pixel p = start + k*len + t, where k < repeat count and t is one of the output's toggle offsets. An output inverts once per frame hit, and the inversion is visible from the next pixel count onward.
- R5: `grp_sel[i]` = 0 assigns `xv[i]` to group A and 1 assigns it to group B. Bit 0 maps to `xv[0]`, the first output. The assigned group supplies the frame, the polarity and the toggles.
- R6: With `merge_en` = 1, every output uses the union of its A and B toggle offsets inside group A's frame, starting from A's polarity. Group B's frame and polarity have no effect. An A offset and a B offset that land on the same pixel produce a single inversion.
- R7: The repeat count is taken from `*_rep_odd` on odd lines and from `*_rep_even` on even lines. The pattern itself is the same on both.
- R8: A repeat count of 0 or a length of 0 disables a group. Outputs driven by a disabled group hold their start polarity for the whole line.
- R9: A toggle offset greater than or equal to the group length never causes an inversion.
- R10: A pattern that runs past the end of the line is cut off at the line boundary. An inversion due at the last pixel of a line does not carry into the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_len | input | 14 | Pixels per line (1 to 8192) |
| grp_sel | input | 13 | Per-output group choice, 1 = group B |
| merge_en | input | 1 | Union of both toggle tables in group A's frame |
| a_start | input | 13 | Group A first pixel |
| a_len | input | 13 | Group A repeat spacing |
| a_rep_odd | input | 8 | Group A repeats on odd lines |
| a_rep_even | input | 8 | Group A repeats on even lines |
| a_pol | input | 13 | Group A start polarity per output |
| a_tog | input | 1014 | Group A toggle offsets, 13 outputs x 6 x 13 bits |
| b_start | input | 13 | Group B first pixel |
| b_len | input | 13 | Group B repeat spacing |
| b_rep_odd | input | 8 | Group B repeats on odd lines |
| b_rep_even | input | 8 | Group B repeats on even lines |
| b_pol | input | 13 | Group B start polarity per output |
| b_tog | input | 1014 | Group B toggle offsets, 13 outputs x 6 x 13 bits |
| pix_cnt | output | 13 | Current pixel within the line |
| line_odd | output | 1 | 1 on odd lines |
| xv | output | 13 | Vertical transfer clocks |

## Verification
If a frame tracker holds a wrong phase or repeat index, every output driven by that group shifts its edges. This shows at the ports in the pixel right after the first misplaced hit. It also leaves an extra or missing edge that lasts until the line wraps. A stale toggle state shows at the next pixel 0, because the output then differs from its start polarity. A parity error swaps the odd and even repeat counts, so it appears as soon as a line is reached where those counts differ. Each line is therefore compared pixel by pixel against a frame model. Lines are chosen so that hits fall on the first pixel, on the last pixel, at the length boundary, and in coinciding A/B positions.

// File: rtl/vts_pkg.sv
`timescale 1ns/1ps
package vts_pkg;
    localparam int XV_N  = 13;          // vertical outputs
    localparam int PIX_W = 13;          // pixel position width
    localparam int TOG_N = 6;           // toggle offsets per output and group
    localparam int REP_W = 8;           // repeat count width
    localparam int LEN_W = PIX_W + 1;   // line length reaches 2**PIX_W
    localparam int GRP_N = 2;           // pattern groups A and B

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [REP_W-1:0] rep_t;
    typedef logic [TOG_N-1:0][PIX_W-1:0] tog_row_t;

    typedef struct packed {
        pix_t start;
        pix_t len;
        rep_t rep_odd;
        rep_t rep_even;
    } frame_cfg_t;

    typedef struct packed {
        logic live;
        pix_t phase;
    } frame_pos_t;

    typedef enum logic [1:0] {
        SRC_A      = 2'd0,
        SRC_B      = 2'd1,
        SRC_MERGED = 2'd2
    } src_e;

    function automatic logic tog_hit(pix_t tog, pix_t len, frame_pos_t pos);
        return pos.live && (tog < len) && (tog == pos.phase);
    endfunction

    function automatic logic row_hit(tog_row_t row, pix_t len, frame_pos_t pos);
        logic any;
        any = 1'b0;
        for (int t = 0; t < TOG_N; t++) begin
            any = any | tog_hit(row[t], len, pos);
        end
        return any;
    endfunction
endpackage

// File: rtl/vts_line_timer.sv
`timescale 1ns/1ps
module vts_line_timer
    import vts_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] line_len,
    output pix_t             pix,
    output logic             odd,
    output logic             wrap
);
    logic [LEN_W-1:0] next_pix;

    assign next_pix = {1'b0, pix} + LEN_W'(1);
    assign wrap     = (next_pix >= line_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix <= '0;
            odd <= 1'b1;
        end else if (wrap) begin
            pix <= '0;
            odd <= ~odd;
        end else begin
            pix <= next_pix[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/vts_frame_tracker.sv
`timescale 1ns/1ps
module vts_frame_tracker
    import vts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pix_t       pix,
    input  logic       odd,
    input  logic       wrap,
    input  frame_cfg_t cfg,
    output frame_pos_t pos
);
    rep_t rep;
    logic enabled;
    logic run_q;
    pix_t ph_q;
    rep_t k_q;
    rep_t k_cur;

    assign rep     = odd ? cfg.rep_odd : cfg.rep_even;
    assign enabled = (rep != '0) && (cfg.len != '0);

    always_comb begin
        pos   = '0;
        k_cur = '0;
        if (enabled && (pix == cfg.start)) begin
            pos.live = 1'b1;
        end else begin
            pos.live  = run_q && enabled;
            pos.phase = ph_q;
            k_cur     = k_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            run_q <= 1'b0;
            ph_q  <= '0;
            k_q   <= '0;
        end else if (pos.live) begin
            if (pos.phase == cfg.len - PIX_W'(1)) begin
                ph_q <= '0;
                if (k_cur == rep - REP_W'(1)) begin
                    run_q <= 1'b0;
                    k_q   <= '0;
                end else begin
                    run_q <= 1'b1;
                    k_q   <= k_cur + REP_W'(1);
                end
            end else begin
                run_q <= 1'b1;
                ph_q  <= pos.phase + PIX_W'(1);
                k_q   <= k_cur;
            end
        end else begin
            run_q <= 1'b0;
        end
    end
endmodule

// File: rtl/vts_xv_lane.sv
`timescale 1ns/1ps
module vts_xv_lane
    import vts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wrap,
    input  src_e       src,
    input  frame_pos_t pos_a,
    input  frame_pos_t pos_b,
    input  pix_t       len_a,
    input  pix_t       len_b,
    input  tog_row_t   tog_a,
    input  tog_row_t   tog_b,
    input  logic       pol_a,
    input  logic       pol_b,
    output logic       xv
);
    logic hit_a;
    logic hit_b_own;
    logic hit_b_in_a;
    logic hit;
    logic pol;
    logic flip_q;

    assign hit_a      = row_hit(tog_a, len_a, pos_a);
    assign hit_b_own  = row_hit(tog_b, len_b, pos_b);
    assign hit_b_in_a = row_hit(tog_b, len_a, pos_a);

    always_comb begin
        unique case (src)
            SRC_B: begin
                hit = hit_b_own;
                pol = pol_b;
            end
            SRC_MERGED: begin
                hit = hit_a | hit_b_in_a;
                pol = pol_a;
            end
            default: begin
                hit = hit_a;
                pol = pol_a;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            flip_q <= 1'b0;
        end else if (hit) begin
            flip_q <= ~flip_q;
        end
    end

    assign xv = pol ^ flip_q;
endmodule

// File: rtl/vts_vertical_seq.sv
`timescale 1ns/1ps
module vts_vertical_seq
    import vts_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [LEN_W-1:0]                      line_len,
    input  logic [XV_N-1:0]                       grp_sel,
    input  logic                                  merge_en,
    input  logic [PIX_W-1:0]                      a_start,
    input  logic [PIX_W-1:0]                      a_len,
    input  logic [REP_W-1:0]                      a_rep_odd,
    input  logic [REP_W-1:0]                      a_rep_even,
    input  logic [XV_N-1:0]                       a_pol,
    input  logic [XV_N-1:0][TOG_N-1:0][PIX_W-1:0] a_tog,
    input  logic [PIX_W-1:0]                      b_start,
    input  logic [PIX_W-1:0]                      b_len,
    input  logic [REP_W-1:0]                      b_rep_odd,
    input  logic [REP_W-1:0]                      b_rep_even,
    input  logic [XV_N-1:0]                       b_pol,
    input  logic [XV_N-1:0][TOG_N-1:0][PIX_W-1:0] b_tog,
    output logic [PIX_W-1:0]                      pix_cnt,
    output logic                                  line_odd,
    output logic [XV_N-1:0]                       xv
);
    logic       wrap;
    frame_cfg_t cfg [GRP_N];
    frame_pos_t pos [GRP_N];
    src_e       lane_src [XV_N];

    assign cfg[0] = '{start: a_start, len: a_len, rep_odd: a_rep_odd, rep_even: a_rep_even};
    assign cfg[1] = '{start: b_start, len: b_len, rep_odd: b_rep_odd, rep_even: b_rep_even};

    vts_line_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .line_len (line_len),
        .pix      (pix_cnt),
        .odd      (line_odd),
        .wrap     (wrap)
    );

    for (genvar g = 0; g < GRP_N; g++) begin : g_frame
        vts_frame_tracker u_trk (
            .clk  (clk),
            .rst  (rst),
            .pix  (pix_cnt),
            .odd  (line_odd),
            .wrap (wrap),
            .cfg  (cfg[g]),
            .pos  (pos[g])
        );
    end

    for (genvar i = 0; i < XV_N; i++) begin : g_lane
        assign lane_src[i] = merge_en   ? SRC_MERGED :
                             grp_sel[i] ? SRC_B : SRC_A;

        vts_xv_lane u_lane (
            .clk   (clk),
            .rst   (rst),
            .wrap  (wrap),
            .src   (lane_src[i]),
            .pos_a (pos[0]),
            .pos_b (pos[1]),
            .len_a (a_len),
            .len_b (b_len),
            .tog_a (a_tog[i]),
            .tog_b (b_tog[i]),
            .pol_a (a_pol[i]),
            .pol_b (b_pol[i]),
            .xv    (xv[i])
        );
    end
endmodule

// File: rtl/vts_checker.sv
`timescale 1ns/1ps
module vts_checker
    import vts_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [LEN_W-1:0] line_len,
    input logic [XV_N-1:0]  grp_sel,
    input logic             merge_en,
    input logic [XV_N-1:0]  a_pol,
    input logic [XV_N-1:0]  b_pol,
    input logic [PIX_W-1:0] pix_cnt,
    input logic             line_odd,
    input logic [XV_N-1:0]  xv
);
    logic             at_end;
    logic [XV_N-1:0]  gov_pol;

    assign at_end  = (({1'b0, pix_cnt} + LEN_W'(1)) >= line_len);
    assign gov_pol = merge_en ? a_pol : ((a_pol & ~grp_sel) | (b_pol & grp_sel));

    p_count_r1: assert property (@(posedge clk) disable iff (rst)
        !at_end |=> (pix_cnt == $past(pix_cnt) + PIX_W'(1)));

    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        at_end |=> (pix_cnt == '0));

    p_parity_flip_r2: assert property (@(posedge clk) disable iff (rst)
        at_end |=> (line_odd != $past(line_odd)));

    p_parity_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !at_end |=> $stable(line_odd));

    p_line_start_pol_r3: assert property (@(posedge clk) disable iff (rst)
        (pix_cnt == '0) |-> (xv == gov_pol));
endmodule

bind vts_vertical_seq vts_checker u_chk (.*);

// File: tb/vts_vertical_seq_test.sv
`timescale 1ns/1ps
module vts_vertical_seq_test;
    import vts_pkg::*;

    typedef struct {
        int                pix;
        logic              odd;
        logic [XV_N-1:0]   xv;
        logic [8*3-1:0]    tag;
    } exp_t;

    logic                                  clk = 1'b0;
    logic                                  rst = 1'b1;
    logic [LEN_W-1:0]                      line_len = LEN_W'(40);
    logic [XV_N-1:0]                       grp_sel = '0;
    logic                                  merge_en = 1'b0;
    logic [PIX_W-1:0]                      a_start = '0, a_len = '0, b_start = '0, b_len = '0;
    logic [REP_W-1:0]                      a_rep_odd = '0, a_rep_even = '0;
    logic [REP_W-1:0]                      b_rep_odd = '0, b_rep_even = '0;
    logic [XV_N-1:0]                       a_pol = 13'h0A5A, b_pol = 13'h1234;
    logic [XV_N-1:0][TOG_N-1:0][PIX_W-1:0] a_tog = '1, b_tog = '1;
    logic [PIX_W-1:0]                      pix_cnt;
    logic                                  line_odd;
    logic [XV_N-1:0]                       xv;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   exp_odd = 1'b1;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    vts_vertical_seq uut (.*);

    function automatic bit frame_hit(int p, int start, int len, int rep, tog_row_t row);
        int off;
        int ph;
        if (rep == 0 || len == 0 || p < start) return 1'b0;
        off = p - start;
        if (off / len >= rep) return 1'b0;
        ph = off % len;
        for (int t = 0; t < TOG_N; t++) begin
            if (int'(row[t]) < len && int'(row[t]) == ph) return 1'b1;
        end
        return 1'b0;
    endfunction

    // waits for the clock edge that starts a new line, then sits mid-pixel 0
    task automatic next_line();
        do @(negedge clk); while (int'(pix_cnt) != int'(line_len) - 1);
        @(posedge clk);
        #1;
        exp_odd = ~exp_odd;
    endtask

    // driver: pushes the expected outputs of every pixel of the current line
    task automatic expect_line(input logic [8*3-1:0] tag);
        logic [XV_N-1:0] flips;
        logic [XV_N-1:0] pol;
        int ra;
        int rb;
        exp_t e;
        flips = '0;
        ra = exp_odd ? int'(a_rep_odd) : int'(a_rep_even);
        rb = exp_odd ? int'(b_rep_odd) : int'(b_rep_even);
        pol = merge_en ? a_pol : ((a_pol & ~grp_sel) | (b_pol & grp_sel));
        for (int p = 0; p < int'(line_len); p++) begin
            e.pix = p;
            e.odd = exp_odd;
            e.xv  = pol ^ flips;
            e.tag = (p == 0) ? "R3" : tag;
            q.push_back(e);
            for (int i = 0; i < XV_N; i++) begin
                bit h;
                if (merge_en)
                    h = frame_hit(p, int'(a_start), int'(a_len), ra, a_tog[i]) |
                        frame_hit(p, int'(a_start), int'(a_len), ra, b_tog[i]);
                else if (grp_sel[i])
                    h = frame_hit(p, int'(b_start), int'(b_len), rb, b_tog[i]);
                else
                    h = frame_hit(p, int'(a_start), int'(a_len), ra, a_tog[i]);
                if (h) flips[i] = ~flips[i];
            end
        end
    endtask

    // monitor: pops one expected item per pixel, away from the active edge
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (int'(pix_cnt) != e.pix) begin
                errors++;
                $display("FAIL R1 pix_cnt actual %0d expected %0d", pix_cnt, e.pix);
            end
            checks++;
            if (line_odd !== e.odd) begin
                errors++;
                $display("FAIL R2 line_odd actual %0b expected %0b at pixel %0d", line_odd, e.odd, e.pix);
            end
            checks++;
            if (xv !== e.xv) begin
                errors++;
                $display("FAIL %s xv actual %h expected %h at pixel %0d", e.tag, xv, e.xv, e.pix);
            end
        end
    end

    task automatic clear_tog();
        a_tog = '1;
        b_tog = '1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R3: reset state
        checks++;
        if (pix_cnt !== '0 || line_odd !== 1'b1 || xv !== a_pol) begin
            errors++;
            $display("FAIL R3 reset pix/odd/xv actual %0d/%0b/%h expected 0/1/%h", pix_cnt, line_odd, xv, a_pol);
        end
        rst = 1'b0;

        // R4: group A drives all outputs
        next_line();
        clear_tog();
        a_start = 13'd3; a_len = 13'd8; a_rep_odd = 8'd2; a_rep_even = 8'd2;
        for (int i = 0; i < XV_N; i++) begin
            a_tog[i][0] = PIX_W'(i % 7);
            a_tog[i][1] = PIX_W'(5);
        end
        expect_line("R4");

        // R5: mixed selection, group B with its own frame and polarity
        next_line();
        grp_sel = 13'h1555;
        b_start = 13'd10; b_len = 13'd6; b_rep_odd = 8'd3; b_rep_even = 8'd3;
        b_pol = ~a_pol;
        for (int i = 0; i < XV_N; i++) begin
            b_tog[i][0] = PIX_W'((i + 1) % 6);
            b_tog[i][2] = PIX_W'(3);
        end
        expect_line("R5");

        // R7: odd and even repeat counts differ, two lines
        next_line();
        grp_sel = '0;
        a_rep_odd = 8'd3; a_rep_even = 8'd1;
        expect_line("R7");
        next_line();
        expect_line("R7");

        // R6: merged mode, B frame and polarity ignored, some coincident offsets
        next_line();
        merge_en = 1'b1;
        grp_sel = 13'h0F0F;
        b_start = 13'd0; b_len = 13'd2; b_pol = 13'h1FFF;
        for (int i = 0; i < XV_N; i++) begin
            b_tog[i][0] = (i % 2 == 0) ? a_tog[i][0] : PIX_W'(7);
            b_tog[i][2] = PIX_W'(2);
        end
        expect_line("R6");
        next_line();
        expect_line("R6");

        // R8: repeat count 0 holds polarity for the line
        next_line();
        merge_en = 1'b0;
        grp_sel = 13'h00FF;
        a_rep_odd = 8'd0; a_rep_even = 8'd0;
        b_rep_odd = 8'd0; b_rep_even = 8'd0;
        expect_line("R8");
        // R8: length 0 disables the group
        next_line();
        a_rep_odd = 8'd4; a_rep_even = 8'd4; a_len = 13'd0;
        b_rep_odd = 8'd4; b_rep_even = 8'd4; b_len = 13'd0;
        expect_line("R8");

        // R9: offsets at or above the length are ignored, start at pixel 0
        next_line();
        grp_sel = '0;
        clear_tog();
        a_start = 13'd0; a_len = 13'd8; a_rep_odd = 8'd4; a_rep_even = 8'd4;
        for (int i = 0; i < XV_N; i++) begin
            a_tog[i][0] = PIX_W'(8);
            a_tog[i][1] = PIX_W'(i % 3);
            a_tog[i][4] = PIX_W'(9 + i);
        end
        expect_line("R9");

        // R10: pattern cut at line end, hit on last pixel dropped
        next_line();
        clear_tog();
        a_start = 13'd30; a_len = 13'd8; a_rep_odd = 8'd3; a_rep_even = 8'd3;
        for (int i = 0; i < XV_N; i++) begin
            a_tog[i][0] = PIX_W'(1);
            a_tog[i][1] = PIX_W'(i % 8);
        end
        expect_line("R10");
        next_line();
        expect_line("R10");

        // R1: short line, then the longest line
        next_line();
        line_len = LEN_W'(5);
        a_start = 13'd1; a_len = 13'd2; a_rep_odd = 8'd2; a_rep_even = 8'd2;
        expect_line("R1");
        next_line();
        line_len = LEN_W'(8192);
        a_start = 13'd8180; a_len = 13'd5; a_rep_odd = 8'd3; a_rep_even = 8'd3;
        expect_line("R1");
        next_line();
        line_len = LEN_W'(12);
        expect_line("R2");

        wait (q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired, actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule